// File: doc/BRIEF.md
# Holdover Clock Regenerator

This block rebuilds a slow external reference clock (nominally 2 MHz) inside a fast system clock domain (nominally 100 MHz). A numerically controlled phase accumulator produces the regenerated square wave. Its step size, the frequency word, sits in a saturating up/down counter. The counter is nudged by one count each time a rising edge of the reference arrives. An edge that lands while the regenerated wave is low raises the word. An edge that lands while it is high lowers it.

When the reference goes quiet, the word stops moving, so the output keeps running at the last frequency it learned. A status flag reports this holdover state once the reference has been absent for a set number of system clocks. A one-cycle tick, aligned to each rising transition of the regenerated wave, serves downstream logic as a clock enable. That logic then needs no second clock.

Top module: `holdover_clk_regen`

## Requirements
- R1: While reset is low at a clock edge, the block returns to a fixed state: frequency word equals NOM_WORD, accumulator zero, square output 0, tick 0 and holdover 0.
- R2: Every system clock the accumulator grows by the current frequency word, modulo 2^ACC_W. The square output is the accumulator's most significant bit.
- R3: A reference rising edge detected while the square output is 0 raises the frequency word by one.
- R4: A reference rising edge detected while the square output is 1 lowers the frequency word by one.
- R5: The frequency word never leaves the range MIN_WORD to MAX_WORD. A step that would cross a bound leaves the word at that bound.
- R6: In every cycle without a detected reference edge the frequency word keeps its value, so the output frequency is held once the reference stops.
- R7: The tick output is high for exactly one cycle on each 0-to-1 transition of the square output, and is low otherwise.
- R8: The holdover output rises once LOSS_CYCLES consecutive system clocks have passed without a detected edge. It falls in the cycle after the next detected edge.
- R9: The reference passes through two synchronizer flops before edge detection. A reference rise sampled at clock edge k changes the frequency word at clock edge k+2. It causes exactly one step, however long the reference stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ref_i | input | 1 | Asynchronous slow reference clock |
| square_o | output | 1 | Regenerated square wave (accumulator MSB) |
| tick_o | output | 1 | One-cycle pulse on each rise of square_o |
| freq_word_o | output | ACC_W | Current frequency word |
| holdover_o | output | 1 | High while the reference is considered lost |

## Verification
The assertions assume two things about the reference. First, it is slow against the system clock, so every rise reaches the edge detector as a separate one-cycle pulse. Second, MIN_WORD is at least 1 and MAX_WORD is below half the accumulator range, so the square wave can never rise on two cycles in a row. The stimulus meets both. It changes the reference only on the falling system clock edge and holds every reference level for at least two system clocks. It uses a small configuration whose bounds lie well inside the accumulator range. It sweeps the reference period from faster than nominal to slower than nominal, and tries both narrow and wide high phases. It then removes the reference long enough to enter holdover, and restarts it.

// File: rtl/hc_regen_pkg.sv
// Package: hc_regen_pkg
// Shared types and helpers for the holdover clock regenerator.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package hc_regen_pkg;

    // Direction the frequency word moves in one cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Decide the frequency step from the edge pulse and the wave phase.
    function automatic step_e hc_pick_step(input logic edge_seen, input logic phase_hi);
        if (!edge_seen) begin
            return STEP_HOLD;
        end else if (phase_hi) begin
            return STEP_DOWN;
        end else begin
            return STEP_UP;
        end
    endfunction

endpackage

// File: rtl/hc_ref_sync.sv
// Module: hc_ref_sync
// Brings the asynchronous reference into the system clock domain through
// a chain of SYNC_STAGES flops and emits a one-cycle pulse on each rise of
// the synchronized level.
// Assumes: each reference level lasts at least two system clocks.
module hc_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic edge_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the reference through the synchronizer and keep the last level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
            prev_q <= sync_q[LAST];
        end
    end

    // Rising-edge pulse, exactly one system clock wide.
    always_comb begin
        edge_o = sync_q[LAST] & ~prev_q;
    end

endmodule

// File: rtl/hc_freq_ctl.sv
// Module: hc_freq_ctl
// Holds the frequency word in a saturating up/down counter. An edge pulse
// while the wave is low counts up, while it is high counts down; with no
// pulse the word is kept.
// Assumes: MIN_WORD <= NOM_WORD <= MAX_WORD.
module hc_freq_ctl
    import hc_regen_pkg::*;
#(
    parameter int          ACC_W    = 32,
    parameter logic [31:0] NOM_WORD = 32'd85899346,
    parameter logic [31:0] MIN_WORD = 32'd81705042,
    parameter logic [31:0] MAX_WORD = 32'd90093650
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    input  logic             phase_hi_i,
    output logic [ACC_W-1:0] word_o
);

    localparam logic [ACC_W-1:0] NOM_W = NOM_WORD[ACC_W-1:0];
    localparam logic [ACC_W-1:0] MIN_W = MIN_WORD[ACC_W-1:0];
    localparam logic [ACC_W-1:0] MAX_W = MAX_WORD[ACC_W-1:0];

    step_e            step;
    logic [ACC_W-1:0] word_q;

    // Choose this cycle's step from the edge pulse and current phase.
    always_comb begin
        step = hc_pick_step(edge_i, phase_hi_i);
    end

    // Apply the step, clamping at the programmed bounds.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q <= NOM_W;
        end else begin
            case (step)
                STEP_UP:   if (word_q < MAX_W) word_q <= word_q + 1'b1;
                STEP_DOWN: if (word_q > MIN_W) word_q <= word_q - 1'b1;
                default:   word_q <= word_q;
            endcase
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/hc_phase_acc.sv
// Module: hc_phase_acc
// Phase accumulator: adds the frequency word every clock; its top bit is the
// regenerated square wave. A tick marks each 0-to-1 change of that bit.
// Assumes: the word stays below 2^(ACC_W-1), so the top bit never rises
// on two consecutive clocks.
module hc_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] word_i,
    output logic             square_o,
    output logic             tick_o
);

    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] acc_q;
    logic             msb_q;

    // Advance the phase and remember the previous top bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
            msb_q <= 1'b0;
        end else begin
            acc_q <= acc_q + word_i;
            msb_q <= acc_q[MSB];
        end
    end

    // Square output and its rising-transition tick.
    always_comb begin
        square_o = acc_q[MSB];
        tick_o   = acc_q[MSB] & ~msb_q;
    end

endmodule

// File: rtl/hc_loss_mon.sv
// Module: hc_loss_mon
// Counts system clocks since the last reference edge, saturating at
// LOSS_CYCLES; the holdover flag is high while the count sits there.
// Assumes: LOSS_CYCLES >= 1.
module hc_loss_mon #(
    parameter int LOSS_CYCLES = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    output logic holdover_o
);

    localparam int                CNT_W = $clog2(LOSS_CYCLES + 1);
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(LOSS_CYCLES);

    logic [CNT_W-1:0] gap_q;

    // Restart on an edge, otherwise count up to the limit and stay.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q <= '0;
        end else if (edge_i) begin
            gap_q <= '0;
        end else if (gap_q != LIMIT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Holdover while the gap counter is at its limit.
    always_comb begin
        holdover_o = (gap_q == LIMIT);
    end

endmodule

// File: rtl/holdover_clk_regen.sv
// Module: holdover_clk_regen
// Top of the holdover clock regenerator: synchronizer and edge detector,
// saturating frequency counter, phase accumulator and loss monitor.
// Assumes: one fast system clock; reference much slower than it.
module holdover_clk_regen #(
    parameter int          ACC_W       = 32,
    parameter logic [31:0] NOM_WORD    = 32'd85899346,
    parameter logic [31:0] MIN_WORD    = 32'd81705042,
    parameter logic [31:0] MAX_WORD    = 32'd90093650,
    parameter int          LOSS_CYCLES = 200
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_i,
    output logic             square_o,
    output logic             tick_o,
    output logic [ACC_W-1:0] freq_word_o,
    output logic             holdover_o
);

    logic             ref_edge;
    logic [ACC_W-1:0] word;
    logic             square;

    hc_ref_sync #(
        .SYNC_STAGES(2)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ref_i (ref_i),
        .edge_o(ref_edge)
    );

    hc_freq_ctl #(
        .ACC_W   (ACC_W),
        .NOM_WORD(NOM_WORD),
        .MIN_WORD(MIN_WORD),
        .MAX_WORD(MAX_WORD)
    ) u_freq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .edge_i    (ref_edge),
        .phase_hi_i(square),
        .word_o    (word)
    );

    hc_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .word_i  (word),
        .square_o(square),
        .tick_o  (tick_o)
    );

    hc_loss_mon #(
        .LOSS_CYCLES(LOSS_CYCLES)
    ) u_loss (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .edge_i    (ref_edge),
        .holdover_o(holdover_o)
    );

    assign square_o    = square;
    assign freq_word_o = word;

endmodule

// File: rtl/hc_regen_chk.sv
// Module: hc_regen_chk
// Property checker for holdover_clk_regen, attached through bind.
// Assumes: MIN_WORD >= 1 and MAX_WORD < 2^(ACC_W-1).
module hc_regen_chk #(
    parameter int          ACC_W    = 32,
    parameter logic [31:0] MIN_WORD = 32'd1,
    parameter logic [31:0] MAX_WORD = 32'd2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             edge_i,
    input logic             square_i,
    input logic             tick_i,
    input logic [ACC_W-1:0] word_i,
    input logic             holdover_i
);

    localparam logic [ACC_W-1:0] MIN_W = MIN_WORD[ACC_W-1:0];
    localparam logic [ACC_W-1:0] MAX_W = MAX_WORD[ACC_W-1:0];

    // R5
    word_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_i >= MIN_W) && (word_i <= MAX_W));

    // R6
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_i |=> $stable(word_i));

    // R3
    step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_i && !square_i && word_i < MAX_W) |=> word_i == $past(word_i) + 1'b1);

    // R4
    step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_i && square_i && word_i > MIN_W) |=> word_i == $past(word_i) - 1'b1);

    // R7
    tick_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> square_i);

    // R7
    tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i);

    // R8
    hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |=> !holdover_i);

endmodule

bind holdover_clk_regen hc_regen_chk #(
    .ACC_W   (ACC_W),
    .MIN_WORD(MIN_WORD),
    .MAX_WORD(MAX_WORD)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (ref_edge),
    .square_i  (square_o),
    .tick_i    (tick_o),
    .word_i    (freq_word_o),
    .holdover_i(holdover_o)
);

// File: tb/sim_holdover_clk_regen.sv
// Bench for holdover_clk_regen in a small configuration: an arithmetic
// model built from the requirements is compared on every falling edge.
module sim_holdover_clk_regen;

    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 8;
    localparam logic [31:0] NOM        = 32'd16;
    localparam logic [31:0] LO         = 32'd12;
    localparam logic [31:0] HI         = 32'd20;
    localparam int          LOSS       = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_in = 1'b0;
    logic         square, tick, holdover;
    logic [W-1:0] word;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  compare = 1'b0;

    // Model state, updated on rising edges.
    logic [W-1:0] m_acc, m_word;
    logic         m_msbq, m_s1, m_s2, m_s3;
    int           m_gap;

    always #(CLK_PERIOD/2) clk = ~clk;

    holdover_clk_regen #(
        .ACC_W      (W),
        .NOM_WORD   (NOM),
        .MIN_WORD   (LO),
        .MAX_WORD   (HI),
        .LOSS_CYCLES(LOSS)
    ) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_i      (ref_in),
        .square_o   (square),
        .tick_o     (tick),
        .freq_word_o(word),
        .holdover_o (holdover)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: synchronizer, edge rule, clamped counter, accumulator, gap count.
    always @(posedge clk) begin
        logic e, msb;
        logic [W-1:0] nw;
        if (!rst_n) begin
            m_acc = '0; m_word = NOM[W-1:0]; m_msbq = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_gap = 0;
        end else begin
            e   = m_s2 && !m_s3;
            msb = m_acc[W-1];
            nw  = m_word;
            if (e && !msb && m_word < HI[W-1:0]) nw = m_word + 1;
            if (e && msb && m_word > LO[W-1:0])  nw = m_word - 1;
            m_msbq = msb;
            m_acc  = m_acc + m_word;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
            if (e) m_gap = 0; else if (m_gap < LOSS) m_gap++;
            m_word = nw;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (compare && rst_n) begin
            check(word == m_word, "R3 R4 R5 R6 word", word, m_word);
            check(square == m_acc[W-1], "R2 square", square, m_acc[W-1]);
            check(tick == (m_acc[W-1] && !m_msbq), "R7 tick", tick, m_acc[W-1] && !m_msbq);
            check(holdover == (m_gap == LOSS), "R8 holdover", holdover, m_gap == LOSS);
            check(word >= LO[W-1:0] && word <= HI[W-1:0], "R5 bounds", word, HI);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive cnt reference periods of len clocks with hi clocks high.
    task automatic ref_run(input int len, input int hi, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            ref_in = 1'b1; cycles(hi);
            ref_in = 1'b0; cycles(len - hi);
        end
    endtask

    initial begin
        logic [W-1:0] held;
        cycles(3);
        // R1: reset state
        check(word == NOM[W-1:0], "R1 word", word, NOM);
        check(square == 1'b0, "R1 square", square, 0);
        check(tick == 1'b0, "R1 tick", tick, 0);
        check(holdover == 1'b0, "R1 holdover", holdover, 0);
        rst_n = 1'b1;
        compare = 1'b1;
        cycles(2);

        // R9: a rise sampled at edge k moves the word at edge k+2
        held = word;
        ref_in = 1'b1;           // sampled at next rising edge k
        @(negedge clk);          // after edge k
        check(word == held, "R9 latency k", word, held);
        @(negedge clk);          // after edge k+1
        check(word == held, "R9 latency k+1", word, held);
        @(negedge clk);          // after edge k+2
        check(word != held, "R9 latency k+2", word, held);
        held = word;
        cycles(30);              // long high: single step only
        check(word == held, "R9 one step per rise", word, held);
        ref_in = 1'b0;
        cycles(4);

        // Sweep reference periods around nominal, narrow and wide highs
        for (int p = 6; p <= 40; p += 2) begin
            ref_run(p, 2, 12);
            ref_run(p, p / 2, 12);
        end
        ref_run(6, 3, 80);       // fast reference pushes toward the upper bound
        ref_run(48, 24, 40);     // slow reference pushes toward the lower bound

        // R6 / R8: reference lost, word frozen, holdover entered
        cycles(4);
        held = word;
        cycles(LOSS + 60);
        check(word == held, "R6 word frozen", word, held);
        check(holdover == 1'b1, "R8 holdover set", holdover, 1);
        cycles(200);
        check(word == held, "R6 word still frozen", word, held);

        // R8: recovery clears holdover
        ref_run(16, 8, 1);
        check(holdover == 1'b0, "R8 holdover cleared", holdover, 0);
        ref_run(16, 8, 20);

        // R1: reset mid-run restores start state
        rst_n = 1'b0;
        cycles(2);
        check(word == NOM[W-1:0], "R1 word after rerun reset", word, NOM);
        check(square == 1'b0 && tick == 1'b0 && holdover == 1'b0, "R1 outputs", square, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule